// File: doc/BRIEF.md
# Cascaded Interrupt Priority Resolver

This block holds the request and in-service state of two chained eight-line interrupt controllers, sixteen lines in all. The lower controller owns lines 0 to 7 and the upper controller owns lines 8 to 15. Single-cycle strobes raise or lower a request line. The block reports whether any unmasked request is waiting and, if one is, the vector of the request with the highest priority.

An acknowledge strobe carries a vector. The block maps that vector back to a line, marks the line in service and, for edge-triggered lines, drops the request. Two trigger-mode registers choose edge or level behaviour for each line. Host writes to these registers are limited by a fixed keep-mask. Masks and vector base bytes come from outside the block as plain inputs. Each controller has an in-service clear input that end-of-interrupt logic elsewhere uses to retire lines.

Top module: `cascade_irq_resolver`

## Requirements
- R1: A raise strobe whose line number is 0 to 15 sets that line's request bit on the next clock. Lines 0-7 are lower bits 0-7 and lines 8-15 are upper bits 0-7. A raise with line 16 or above asserts `raise_rej` in the same cycle and changes no state.
- R2: A raise on line 2 sets lower request bit 2 and also sets upper request bit 1 (line 9).
- R3: A lower strobe clears the request bit of its line on the next clock.
- R4: `pending` is 1 exactly when some request bit is set whose mask bit is 0, in either controller.
- R5: The winning request is the lowest-numbered unmasked line, and every lower-controller line comes before every upper-controller line. `win_vec` is the winner's bit index added to its controller's base byte, modulo 256. `win_vec` is 0 when nothing is pending.
- R6: An acknowledge vector selects the lower controller if it lies in [base_lo, base_lo+7] and otherwise selects the upper controller if it lies in [base_hi, base_hi+7]. Neither range wraps past 255. Vector bits [2:0] give the bit index. A vector outside both ranges asserts `ack_rej` and changes no state.
- R7: An accepted acknowledge sets the line's in-service bit. It clears the request bit only when the line's trigger bit is 0 (edge). A 1 (level) leaves the request bit set.
- R8: The trigger registers reset to 0. A write stores the write data ANDed with 0xF8 for the lower controller and with 0xDE for the upper controller. The stored values appear on `trig_lo` and `trig_hi`.
- R9: When a raise and an acknowledge or lower strobe target the same line in one cycle, the request bit ends up set.
- R10: An in-service clear vector clears the in-service bits it selects on the next clock. An acknowledge setting the same bit in the same cycle takes precedence.
- R11: After reset, all request bits, in-service bits and trigger bits are 0, and `pending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_vld | input | 1 | Raise strobe |
| raise_line | input | 5 | Line to raise (16 and above rejected) |
| lower_vld | input | 1 | Lower strobe |
| lower_line | input | 4 | Line to lower |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_vec | input | 8 | Vector being acknowledged |
| mask_lo | input | 8 | Lower-controller mask, 1 = masked |
| mask_hi | input | 8 | Upper-controller mask, 1 = masked |
| base_lo | input | 8 | Lower-controller vector base |
| base_hi | input | 8 | Upper-controller vector base |
| isr_clr_lo | input | 8 | Lower in-service clear bits |
| isr_clr_hi | input | 8 | Upper in-service clear bits |
| trig_we_lo | input | 1 | Write strobe, lower trigger register |
| trig_we_hi | input | 1 | Write strobe, upper trigger register |
| trig_wdata | input | 8 | Trigger register write data |
| pending | output | 1 | An unmasked request exists |
| win_vec | output | 8 | Vector of the winning request |
| raise_rej | output | 1 | Raise line out of range |
| ack_rej | output | 1 | Acknowledge vector matches no controller |
| req_lo | output | 8 | Lower request bits |
| req_hi | output | 8 | Upper request bits |
| isr_lo | output | 8 | Lower in-service bits |
| isr_hi | output | 8 | Upper in-service bits |
| trig_lo | output | 8 | Lower trigger register |
| trig_hi | output | 8 | Upper trigger register |

## Verification
Directed steps first set requests in both controllers under different masks. With lower-controller requests present and then masked off, a wrong lower-before-upper ordering or a wrong bit-index search shows up in `win_vec`. Acknowledges are sent against trigger registers written with all ones and with zeros, which separates edge from level retention. The folded line 2 and the collisions of a raise with an acknowledge or a lower on one line are each tried on their own. Overlapping base windows show whether the lower controller takes precedence in acknowledge decoding, and out-of-range lines and vectors must be rejected with no state change. A long pseudo-random phase then mixes every strobe, mask and base change against the bench's own model.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int BANK_W   = 8;
  localparam int IDX_W    = $clog2(BANK_W);
  localparam int N_BANK   = 2;
  localparam int N_LINES  = BANK_W * N_BANK;
  localparam int FOLD_SRC = 2;
  localparam int FOLD_DST = 9;

  typedef logic [BANK_W-1:0] bank_vec_t;

  // {found, index} of the lowest set bit
  function automatic logic [IDX_W:0] lowest_set(bank_vec_t v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = BANK_W - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  // vector within [base, base+BANK_W-1], no wrap past 255
  function automatic logic in_window(logic [7:0] base, logic [7:0] vec);
    logic [8:0] lo9, hi9, v9;
    lo9 = {1'b0, base};
    hi9 = lo9 + 9'(BANK_W - 1);
    v9  = {1'b0, vec};
    return (v9 >= lo9) && (v9 <= hi9);
  endfunction

  function automatic logic [7:0] make_vector(logic [7:0] base, logic [IDX_W-1:0] idx);
    return base + 8'(idx);
  endfunction
endpackage

// File: rtl/cirq_decode.sv
module cirq_decode
  import cirq_pkg::*;
#(
  parameter int LINE_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          raise_vld,
  input  logic [LINE_W-1:0]             raise_line,
  input  logic                          lower_vld,
  input  logic [3:0]                    lower_line,
  input  logic                          ack_vld,
  input  logic [7:0]                    ack_vec,
  input  logic [7:0]                    base_lo,
  input  logic [7:0]                    base_hi,
  output logic [N_LINES-1:0]            set_all,
  output logic [N_LINES-1:0]            clr_all,
  output logic [N_BANK-1:0][BANK_W-1:0] ack_bits,
  output logic                          raise_rej,
  output logic                          ack_rej
);
  logic raise_ok, hit_lo, hit_hi;

  assign raise_ok  = raise_vld && (int'(raise_line) < N_LINES);
  assign raise_rej = raise_vld && !raise_ok;
  assign hit_lo    = ack_vld && in_window(base_lo, ack_vec);
  assign hit_hi    = ack_vld && !hit_lo && in_window(base_hi, ack_vec);
  assign ack_rej   = ack_vld && !hit_lo && !hit_hi;

  always_comb begin
    set_all = '0;
    clr_all = '0;
    if (raise_ok) begin
      set_all[raise_line[3:0]] = 1'b1;
      if (int'(raise_line) == FOLD_SRC) set_all[FOLD_DST] = 1'b1;
    end
    if (lower_vld) clr_all[lower_line] = 1'b1;
  end

  always_comb begin
    ack_bits = '0;
    if (hit_lo) ack_bits[0][ack_vec[IDX_W-1:0]] = 1'b1;
    if (hit_hi) ack_bits[1][ack_vec[IDX_W-1:0]] = 1'b1;
  end

  assert_raise_rej_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    raise_rej |-> (set_all == '0));
  assert_fold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_vld && int'(raise_line) == FOLD_SRC) |-> (set_all[FOLD_DST] && set_all[FOLD_SRC]));
  assert_ack_single_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|ack_bits[1], |ack_bits[0], ack_rej}));
endmodule

// File: rtl/cirq_bank.sv
module cirq_bank
  import cirq_pkg::*;
#(
  parameter logic [BANK_W-1:0] KEEP = 8'hFF
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bank_vec_t set_req,
  input  bank_vec_t clr_req,
  input  bank_vec_t ack_bit,
  input  bank_vec_t isr_clr,
  input  logic      trig_we,
  input  bank_vec_t trig_wdata,
  output bank_vec_t req_q,
  output bank_vec_t isr_q,
  output bank_vec_t trig_q
);
  bank_vec_t ack_drop;

  assign ack_drop = ack_bit & ~trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      isr_q  <= '0;
      trig_q <= '0;
    end else begin
      req_q <= (req_q & ~clr_req & ~ack_drop) | set_req;
      isr_q <= (isr_q & ~isr_clr) | ack_bit;
      if (trig_we) trig_q <= trig_wdata & KEEP;
    end
  end

  assert_raise_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & $past(set_req)) == $past(set_req)));
  assert_lower_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & $past(clr_req & ~set_req)) == '0));
  assert_edge_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & $past(ack_bit & ~trig_q & ~set_req)) == '0));
  assert_level_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & $past(ack_bit & trig_q & req_q & ~clr_req))
              == $past(ack_bit & trig_q & req_q & ~clr_req)));
  assert_isr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((isr_q & $past(ack_bit)) == $past(ack_bit)));
  assert_isr_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((isr_q & $past(isr_clr & ~ack_bit)) == '0));
  assert_trig_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_we |=> (trig_q == ($past(trig_wdata) & KEEP)));
endmodule

// File: rtl/cirq_arbiter.sv
module cirq_arbiter
  import cirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bank_vec_t req_lo,
  input  bank_vec_t req_hi,
  input  bank_vec_t mask_lo,
  input  bank_vec_t mask_hi,
  input  logic [7:0] base_lo,
  input  logic [7:0] base_hi,
  output logic       pending,
  output logic [7:0] win_vec
);
  bank_vec_t      act_lo, act_hi;
  logic [IDX_W:0] pick_lo, pick_hi;

  assign act_lo  = req_lo & ~mask_lo;
  assign act_hi  = req_hi & ~mask_hi;
  assign pick_lo = lowest_set(act_lo);
  assign pick_hi = lowest_set(act_hi);
  assign pending = pick_lo[IDX_W] | pick_hi[IDX_W];

  always_comb begin
    if (pick_lo[IDX_W])      win_vec = make_vector(base_lo, pick_lo[IDX_W-1:0]);
    else if (pick_hi[IDX_W]) win_vec = make_vector(base_hi, pick_hi[IDX_W-1:0]);
    else                     win_vec = '0;
  end

  logic [7:0] off_lo;
  assign off_lo = win_vec - base_lo;

  assert_lo_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_lo != '0) |-> (off_lo < 8'(BANK_W) && act_lo[off_lo[IDX_W-1:0]]));
  assert_idle_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> (win_vec == '0 && act_lo == '0 && act_hi == '0));
endmodule

// File: rtl/cascade_irq_resolver.sv
module cascade_irq_resolver
  import cirq_pkg::*;
#(
  parameter int          LINE_W       = 5,
  parameter logic [7:0]  TRIG_KEEP_LO = 8'hF8,
  parameter logic [7:0]  TRIG_KEEP_HI = 8'hDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_vld,
  input  logic [LINE_W-1:0] raise_line,
  input  logic              lower_vld,
  input  logic [3:0]        lower_line,
  input  logic              ack_vld,
  input  logic [7:0]        ack_vec,
  input  logic [7:0]        mask_lo,
  input  logic [7:0]        mask_hi,
  input  logic [7:0]        base_lo,
  input  logic [7:0]        base_hi,
  input  logic [7:0]        isr_clr_lo,
  input  logic [7:0]        isr_clr_hi,
  input  logic              trig_we_lo,
  input  logic              trig_we_hi,
  input  logic [7:0]        trig_wdata,
  output logic              pending,
  output logic [7:0]        win_vec,
  output logic              raise_rej,
  output logic              ack_rej,
  output logic [7:0]        req_lo,
  output logic [7:0]        req_hi,
  output logic [7:0]        isr_lo,
  output logic [7:0]        isr_hi,
  output logic [7:0]        trig_lo,
  output logic [7:0]        trig_hi
);
  logic [N_LINES-1:0]            set_all, clr_all;
  logic [N_BANK-1:0][BANK_W-1:0] ack_bits, isr_clr, req_b, isr_b, trig_b;
  logic [N_BANK-1:0]             trig_we;

  assign isr_clr = {isr_clr_hi, isr_clr_lo};
  assign trig_we = {trig_we_hi, trig_we_lo};

  cirq_decode #(.LINE_W(LINE_W)) u_decode (
    .clk(clk), .rst_n(rst_n),
    .raise_vld(raise_vld), .raise_line(raise_line),
    .lower_vld(lower_vld), .lower_line(lower_line),
    .ack_vld(ack_vld), .ack_vec(ack_vec),
    .base_lo(base_lo), .base_hi(base_hi),
    .set_all(set_all), .clr_all(clr_all), .ack_bits(ack_bits),
    .raise_rej(raise_rej), .ack_rej(ack_rej)
  );

  for (genvar g = 0; g < N_BANK; g++) begin : g_bank
    localparam logic [BANK_W-1:0] KEEP_G = (g == 0) ? TRIG_KEEP_LO : TRIG_KEEP_HI;
    cirq_bank #(.KEEP(KEEP_G)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_req(set_all[g*BANK_W +: BANK_W]),
      .clr_req(clr_all[g*BANK_W +: BANK_W]),
      .ack_bit(ack_bits[g]),
      .isr_clr(isr_clr[g]),
      .trig_we(trig_we[g]),
      .trig_wdata(trig_wdata),
      .req_q(req_b[g]), .isr_q(isr_b[g]), .trig_q(trig_b[g])
    );
  end

  cirq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n),
    .req_lo(req_b[0]), .req_hi(req_b[1]),
    .mask_lo(mask_lo), .mask_hi(mask_hi),
    .base_lo(base_lo), .base_hi(base_hi),
    .pending(pending), .win_vec(win_vec)
  );

  assign req_lo  = req_b[0];
  assign req_hi  = req_b[1];
  assign isr_lo  = isr_b[0];
  assign isr_hi  = isr_b[1];
  assign trig_lo = trig_b[0];
  assign trig_hi = trig_b[1];

  assert_reject_no_isr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rej && isr_clr == '0) |=> $stable({isr_hi, isr_lo}));
endmodule

// File: tb/cascade_irq_resolver_bench.sv
module cascade_irq_resolver_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic raise_vld = 0, lower_vld = 0, ack_vld = 0, trig_we_lo = 0, trig_we_hi = 0;
  logic [4:0] raise_line = 0;
  logic [3:0] lower_line = 0;
  logic [7:0] ack_vec = 0, mask_lo = 0, mask_hi = 0, base_lo = 0, base_hi = 0;
  logic [7:0] isr_clr_lo = 0, isr_clr_hi = 0, trig_wdata = 0;
  logic pending, raise_rej, ack_rej;
  logic [7:0] win_vec, req_lo, req_hi, isr_lo, isr_hi, trig_lo, trig_hi;

  cascade_irq_resolver u_cascade_irq_resolver (
    .clk(clk), .rst_n(rst_n), .raise_vld(raise_vld), .raise_line(raise_line),
    .lower_vld(lower_vld), .lower_line(lower_line), .ack_vld(ack_vld), .ack_vec(ack_vec),
    .mask_lo(mask_lo), .mask_hi(mask_hi), .base_lo(base_lo), .base_hi(base_hi),
    .isr_clr_lo(isr_clr_lo), .isr_clr_hi(isr_clr_hi), .trig_we_lo(trig_we_lo),
    .trig_we_hi(trig_we_hi), .trig_wdata(trig_wdata), .pending(pending), .win_vec(win_vec),
    .raise_rej(raise_rej), .ack_rej(ack_rej), .req_lo(req_lo), .req_hi(req_hi),
    .isr_lo(isr_lo), .isr_hi(isr_hi), .trig_lo(trig_lo), .trig_hi(trig_hi)
  );

  bit [15:0] m_req, m_isr;
  bit [7:0]  m_tlo, m_thi;
  int checks = 0, fails = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit in_win(int b, int v);
    return (v >= b) && (v <= b + 7);
  endfunction

  function automatic int ack_line();
    if (!ack_vld) return -1;
    if (in_win(int'(base_lo), int'(ack_vec))) return int'(ack_vec) % 8;
    if (in_win(int'(base_hi), int'(ack_vec))) return 8 + int'(ack_vec) % 8;
    return -1;
  endfunction

  task automatic compare();
    bit [15:0] act;
    bit p;
    int vec;
    act = m_req & ~{mask_hi, mask_lo};
    p = 0;
    vec = 0;
    for (int i = 0; i < 16; i++) begin
      if (!p && act[i]) begin
        p = 1;
        vec = (i < 8) ? (i + int'(base_lo)) % 256 : (i - 8 + int'(base_hi)) % 256;
      end
    end
    chk("R4 pending", int'(pending), int'(p));
    chk("R5 win_vec", int'(win_vec), vec);
    chk("R1 raise_rej", int'(raise_rej), int'(raise_vld && raise_line > 15));
    chk("R6 ack_rej", int'(ack_rej), int'(ack_vld && ack_line() < 0));
    chk("R1 R2 R3 R7 R9 requests", int'({req_hi, req_lo}), int'(m_req));
    chk("R7 R10 in-service", int'({isr_hi, isr_lo}), int'(m_isr));
    chk("R8 trigger regs", int'({trig_hi, trig_lo}), int'({m_thi, m_tlo}));
  endtask

  task automatic model_update();
    bit [15:0] nreq, nisr;
    int L;
    L = ack_line();
    nreq = m_req;
    if (lower_vld) nreq[lower_line] = 1'b0;
    if (L >= 0 && !({m_thi, m_tlo}[L])) nreq[L] = 1'b0;
    if (raise_vld && raise_line < 16) begin
      nreq[raise_line[3:0]] = 1'b1;
      if (raise_line == 2) nreq[9] = 1'b1;
    end
    nisr = m_isr & ~{isr_clr_hi, isr_clr_lo};
    if (L >= 0) nisr[L] = 1'b1;
    if (trig_we_lo) m_tlo = trig_wdata & 8'hF8;
    if (trig_we_hi) m_thi = trig_wdata & 8'hDE;
    m_req = nreq;
    m_isr = nisr;
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
    raise_vld = 0; lower_vld = 0; ack_vld = 0;
    trig_we_lo = 0; trig_we_hi = 0; isr_clr_lo = 0; isr_clr_hi = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 reset requests", int'({req_hi, req_lo}), 0);
    chk("R11 reset in-service", int'({isr_hi, isr_lo}), 0);
    chk("R11 reset trigger", int'({trig_hi, trig_lo}), 0);
    chk("R11 reset pending", int'(pending), 0);
    tick();

    base_lo = 8'h20; base_hi = 8'h28;
    raise_vld = 1; raise_line = 5;  tick();           // R1
    raise_vld = 1; raise_line = 3;  tick();           // R5 lower index wins
    raise_vld = 1; raise_line = 12; tick();
    mask_lo = 8'hFF; tick();                          // R5 upper reached when lower masked
    chk("R5 upper vector", int'(win_vec), 8'h2C);
    mask_lo = 8'h00;
    raise_vld = 1; raise_line = 2;  tick();           // R2 fold
    chk("R2 fold bits", int'({req_hi[1], req_lo[2]}), 3);
    raise_vld = 1; raise_line = 20; tick();           // R1 reject
    lower_vld = 1; lower_line = 3;  tick();           // R3
    trig_we_lo = 1; trig_wdata = 8'hFF; tick();       // R8
    trig_we_hi = 1; trig_wdata = 8'hFF; tick();
    chk("R8 masked writes", int'({trig_hi, trig_lo}), 16'hDEF8);
    ack_vld = 1; ack_vec = 8'h25; tick();             // R7 level line 5 keeps request
    ack_vld = 1; ack_vec = 8'h2C; tick();             // R7 level line 12
    ack_vld = 1; ack_vec = 8'h22; tick();             // R7 edge line 2 drops request
    chk("R7 edge drop", int'(req_lo[2]), 0);
    ack_vld = 1; ack_vec = 8'h50; tick();             // R6 reject
    trig_we_lo = 1; trig_wdata = 8'h00; tick();
    raise_vld = 1; raise_line = 4; ack_vld = 1; ack_vec = 8'h24; tick();   // R9 raise beats ack
    chk("R9 raise beats ack", int'(req_lo[4]), 1);
    raise_vld = 1; raise_line = 4; lower_vld = 1; lower_line = 4; tick();  // R9 raise beats lower
    isr_clr_lo = 8'h20; ack_vld = 1; ack_vec = 8'h25; tick();              // R10 ack wins
    isr_clr_lo = 8'hFF; isr_clr_hi = 8'hFF; tick();                         // R10 clear
    chk("R10 cleared", int'({isr_hi, isr_lo}), 0);
    base_hi = 8'h20; ack_vld = 1; ack_vec = 8'h21; tick();                  // R6 lower first
    base_lo = 8'hFC; base_hi = 8'h08; ack_vld = 1; ack_vec = 8'h01; tick(); // R6 no wrap
    tick();

    for (int n = 0; n < 4000; n++) begin
      raise_vld  = ($urandom % 3) == 0;
      raise_line = 5'($urandom % 19);
      lower_vld  = ($urandom % 4) == 0;
      lower_line = 4'($urandom);
      ack_vld    = ($urandom % 3) == 0;
      ack_vec    = (($urandom % 2) != 0) ? base_lo + 8'($urandom % 10) : base_hi + 8'($urandom % 10);
      if (($urandom % 16) == 0) begin mask_lo = 8'($urandom); mask_hi = 8'($urandom); end
      if (($urandom % 64) == 0) begin base_lo = 8'($urandom); base_hi = 8'($urandom); end
      if (($urandom % 8) == 0) begin isr_clr_lo = 8'($urandom); isr_clr_hi = 8'($urandom); end
      if (($urandom % 32) == 0) begin
        trig_we_lo = 1'($urandom); trig_we_hi = 1'($urandom); trig_wdata = 8'($urandom);
      end
      tick();
    end

    summary();
    $finish;
  end
endmodule